// File: doc/BRIEF.md
# Power-of-Two Reference Clock Divider Channel

This block is one output channel of a clock divider. A reference clock enters and a divided copy of it leaves. The division ratio is a power of two between 1 and 64. A 3-bit logarithmic field selects it: factor n gives ratio 2^(n-1), and factor 0 acts the same as factor 1. Two byte-wide registers sit behind a simple strobe port. One holds the factor. The other holds the requested enable bit, plus a read-only bit that shows whether the output is really toggling.

Switching the output on and off is sequenced so that no pulse is ever shortened. A start waits a fixed arming delay and then begins a period with its high half. A stop lets the period in progress finish and then holds the output low. A factor written while the channel runs takes effect at the next period boundary. Software may also follow the safe order: disable, rewrite the factor, enable again. Each channel decodes its own two addresses. Its base is a start address plus the channel index times 0x100.

Top module: `clkdiv_chan`

## Requirements
- R1: The channel base is BASE_ADDR + CHAN_IDX*0x100. The factor register is at base+0x43 and the enable register is at base+0x46. A write to any other address changes nothing. A read of any other address, or with the read strobe low, returns 0.
- R2: Reset leaves factor 0, enable 0, output low and status 0. In the factor register only bits [2:0] are kept. In the enable register only bit 7 is kept, and bit 0 reads the status. Every other bit reads 0 and ignores writes.
- R3: Factor n in 1..7 divides by 2^(n-1), and factor 0 divides by 1. For a ratio R of 2 or more, the output repeats every R cycles: high for R/2 cycles, then low for R/2.
- R4: Enable is written at edge E. For R of 2 or more, the output is high from edge E+2. For R = 1, the gated reference clock pulses from the cycle that starts at edge E+3. Both are within 2+3R cycles.
- R5: Enable is cleared at edge D. The running period completes, and the output stays low from the first period boundary after D. For R = 1 that boundary is edge D+1, and its pulse is the last one. The stop is always within 3R cycles.
- R6: Status (enable register bit 0) reads 1 exactly while the output is producing periods. It falls when the stop completes. Enable register bit 7 reads back the requested enable.
- R7: A factor written while the output runs changes the ratio only at the next period boundary. Enabling from stopped uses the factor written last.
- R8: If the enable is cleared before the arming delay ends, no pulse appears and status stays 0.
- R9: The output never emits a shortened pulse. Each high phase starts at a period boundary and has full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational |
| clk_out | output | 1 | Divided, gated clock |

## Verification
A disable write can land on the same edge as a period boundary, or on the cycle just before one. A new factor can also arrive at a boundary, and the stop decision and the ratio reload then compete in that one cycle. The bench places the disable write mid-period, one cycle before the boundary and inside the arming window, for every factor from 0 to 7. It also writes a new factor in the middle of a running period. For each reference cycle it computes the expected output level, status and enable readback from the boundary arithmetic, and compares them with both clock phases of the output.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_e;

   // log-encoded factor to division ratio; factor 0 aliases factor 1
   function automatic int unsigned fac_to_ratio(input int unsigned fac);
      int unsigned f;
      f = (fac == 0) ? 1 : fac;
      return 32'd1 << (f - 1);
   endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int FACT_W    = 3,
   parameter int CHAN_BASE = 0,
   parameter int DIV_OFS   = 'h43,
   parameter int EN_OFS    = 'h46,
   parameter int EN_BIT    = 7,
   parameter int STAT_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [FACT_W-1:0] fact_o,
   output logic              en_o,
   input  logic              stat_i
);

   localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(CHAN_BASE + DIV_OFS);
   localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(CHAN_BASE + EN_OFS);

   logic              hit_div;
   logic              hit_en;
   logic [FACT_W-1:0] fact_q;
   logic              en_q;

   assign hit_div = (addr_i == DIV_ADDR);
   assign hit_en  = (addr_i == EN_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fact_q <= '0;
         en_q   <= 1'b0;
      end else if (wr_i) begin
         if (hit_div) fact_q <= wdata_i[FACT_W-1:0];
         if (hit_en)  en_q   <= wdata_i[EN_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (rd_i && hit_div) rdata_o[FACT_W-1:0] = fact_q;
      if (rd_i && hit_en) begin
         rdata_o[EN_BIT]   = en_q;
         rdata_o[STAT_BIT] = stat_i;
      end
   end

   assign fact_o = fact_q;
   assign en_o   = en_q;

   // R1: registers move only on a decoded write
   a_r1_fact_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && hit_div) |=> $stable(fact_q));
   a_r1_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && hit_en) |=> $stable(en_q));
   // R1: no read strobe, no data
   a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> (rdata_o == '0));

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
   import clkdiv_pkg::*;
#(
   parameter int FACT_W  = 3,
   parameter int ARM_CYC = 2,
   parameter int CNT_W   = 6,
   parameter int RAT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [FACT_W-1:0] fact_i,
   output logic              run_o,
   output logic              bypass_o,
   output logic              pulse_o
);

   localparam int ARM_W = (ARM_CYC > 2) ? $clog2(ARM_CYC) : 1;
   localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_CYC - 2);
   localparam logic [RAT_W-1:0] RAT_ONE  = RAT_W'(1);

   seq_state_e       st_q, st_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [RAT_W-1:0] rat_q, rat_n;
   logic [ARM_W-1:0] arm_q, arm_n;
   logic             pulse_q, pulse_n;
   logic [RAT_W-1:0] rat_req;
   logic             at_end;

   assign rat_req = RAT_W'(fac_to_ratio(int'(fact_i)));
   assign at_end  = ({1'b0, cnt_q} == (rat_q - RAT_ONE));

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      rat_n = rat_q;
      arm_n = arm_q;
      unique case (st_q)
         ST_IDLE: begin
            if (en_i) begin
               st_n  = ST_ARM;
               arm_n = '0;
            end
         end
         ST_ARM: begin
            if (!en_i) begin
               st_n = ST_IDLE;
            end else if (arm_q == ARM_LAST) begin
               st_n  = ST_RUN;
               cnt_n = '0;
               rat_n = rat_req;
            end else begin
               arm_n = arm_q + 1'b1;
            end
         end
         ST_RUN: begin
            if (at_end) begin
               cnt_n = '0;
               if (!en_i) st_n  = ST_IDLE;
               else       rat_n = rat_req;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase
      pulse_n = (st_n == ST_RUN) && ({1'b0, cnt_n} < (rat_n >> 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         rat_q   <= RAT_ONE;
         arm_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         st_q    <= st_n;
         cnt_q   <= cnt_n;
         rat_q   <= rat_n;
         arm_q   <= arm_n;
         pulse_q <= pulse_n;
      end
   end

   assign run_o    = (st_q == ST_RUN);
   assign bypass_o = (rat_q == RAT_ONE);
   assign pulse_o  = pulse_q;

   // R3: phase counter stays inside the active period
   a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> ({1'b0, cnt_q} < rat_q));
   // R9: high phase only begins at a period start
   a_r9_rise_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> (cnt_q == '0));
   // R7: ratio frozen inside a period
   a_r7_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && $past(run_o) && cnt_q != '0) |-> $stable(rat_q));
   // R5: a stop always happens at the end of a period
   a_r5_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_o) |-> ($past({1'b0, cnt_q}) == $past(rat_q) - RAT_ONE));
   // R8: a run never starts without a standing request
   a_r8_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> $past(en_i));

endmodule

// File: rtl/clkdiv_outmux.sv
module clkdiv_outmux (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic bypass_i,
   input  logic pulse_i,
   output logic clk_o,
   output logic stat_o
);

   logic gate_q;
   logic runn_q;

   // low-phase capture so the gated reference never yields a runt pulse
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         runn_q <= 1'b0;
      end else begin
         gate_q <= run_i & bypass_i;
         runn_q <= run_i;
      end
   end

   assign clk_o  = bypass_i ? (clk & gate_q) : pulse_i;
   assign stat_o = (run_i & ~bypass_i) | gate_q | (run_i & runn_q);

   // R5: a stopped channel is quiet on the divided path
   a_r5_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !bypass_i) |-> !pulse_i);
   // R6: status never reports while nothing can toggle
   a_r6_status_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o |-> (run_i || gate_q));

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int FACT_W      = 3,
   parameter int BASE_ADDR   = 'h1000,
   parameter int CHAN_IDX    = 1,
   parameter int CHAN_STRIDE = 'h100,
   parameter int DIV_OFS     = 'h43,
   parameter int EN_OFS      = 'h46,
   parameter int EN_BIT      = 7,
   parameter int STAT_BIT    = 0,
   parameter int ARM_CYC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              clk_out
);

   localparam int MAX_FACT  = (1 << FACT_W) - 1;
   localparam int MAX_RATIO = 1 << (MAX_FACT - 1);
   localparam int CNT_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;
   localparam int RAT_W     = CNT_W + 1;
   localparam int CHAN_BASE = BASE_ADDR + CHAN_IDX * CHAN_STRIDE;

   generate
      if (FACT_W < 2 || FACT_W > 4) begin : g_bad_fact_w
         $error("clkdiv_chan: FACT_W must lie in 2..4");
      end
      if (ARM_CYC < 2) begin : g_bad_arm
         $error("clkdiv_chan: ARM_CYC must be at least 2");
      end
      if (EN_BIT >= DATA_W || STAT_BIT >= DATA_W || EN_BIT == STAT_BIT) begin : g_bad_bits
         $error("clkdiv_chan: enable and status bits must be distinct and inside DATA_W");
      end
      if (FACT_W > DATA_W) begin : g_bad_data_w
         $error("clkdiv_chan: factor field wider than data bus");
      end
   endgenerate

   logic [FACT_W-1:0] fact;
   logic              en_req;
   logic              running;
   logic              run;
   logic              bypass;
   logic              pulse;

   clkdiv_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .FACT_W   (FACT_W),
      .CHAN_BASE(CHAN_BASE),
      .DIV_OFS  (DIV_OFS),
      .EN_OFS   (EN_OFS),
      .EN_BIT   (EN_BIT),
      .STAT_BIT (STAT_BIT)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (reg_wr),
      .rd_i   (reg_rd),
      .addr_i (reg_addr),
      .wdata_i(reg_wdata),
      .rdata_o(reg_rdata),
      .fact_o (fact),
      .en_o   (en_req),
      .stat_i (running)
   );

   clkdiv_seq #(
      .FACT_W (FACT_W),
      .ARM_CYC(ARM_CYC),
      .CNT_W  (CNT_W),
      .RAT_W  (RAT_W)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_req),
      .fact_i  (fact),
      .run_o   (run),
      .bypass_o(bypass),
      .pulse_o (pulse)
   );

   clkdiv_outmux i_outmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .bypass_i(bypass),
      .pulse_i (pulse),
      .clk_o   (clk_out),
      .stat_o  (running)
   );

   // R4: the run begins only after the enable request is seen
   a_r4_run_after_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(en_req, 2));

endmodule

// File: tb/test_clkdiv_chan.sv
`timescale 1ns/100ps
module test_clkdiv_chan;

   localparam int A = 2;
   localparam logic [15:0] DIV_A   = 16'h1143;
   localparam logic [15:0] EN_A    = 16'h1146;
   localparam logic [15:0] OTHER_D = 16'h1043;
   localparam logic [15:0] OTHER_E = 16'h1046;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        clk_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkdiv_chan i_clkdiv_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .clk_out  (clk_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input bit strobe, output logic [7:0] d);
      @(negedge clk);
      reg_rd = strobe; reg_addr = a;
      #0.5 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   function automatic int ratio_of(input int f);
      return (f == 0) ? 1 : (1 << (f - 1));
   endfunction

   // enable at edge 0, disable at edge d, compare every cycle
   task automatic run_case(input int f, input int d);
      int r, s, t;
      bit ran, on, e_hi, e_lo, e_st, e_en;
      logic hi, lo;
      logic [7:0] rv;
      r = ratio_of(f);
      wr(DIV_A, 8'(f));
      ran = (d >= A);
      if (r == 1) s = d + 1;
      else        s = A + ((d - A) / r + 1) * r;
      t = d + 3 * r + 6;
      @(negedge clk);
      for (int j = -1; j <= t; j++) begin
         @(posedge clk);
         #1 reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = EN_A;
         #0.5 hi = clk_out; rv = reg_rdata;
         #0.7;
         if (j == -1 || j == d - 1) begin
            reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = EN_A;
            reg_wdata = (j == -1) ? 8'h80 : 8'h00;
         end
         #1.3 lo = clk_out;
         if (r == 1) begin
            on   = ran && j >= A + 1 && j <= s;
            e_hi = on;
            e_lo = 1'b0;
         end else begin
            on   = ran && j >= A && j < s;
            e_hi = on && ((j - A) % r < r / 2);
            e_lo = e_hi;
         end
         e_st = on;
         e_en = (j >= 0 && j < d);
         if (ran) begin
            chk(hi === e_hi, "R3 R4 R5 R9 output high phase", int'(hi), int'(e_hi));
            chk(lo === e_lo, "R3 R9 output low phase", int'(lo), int'(e_lo));
         end else begin
            chk(hi === 1'b0 && lo === 1'b0, "R8 aborted start stays low", int'(hi | lo), 0);
         end
         chk(rv[0] === e_st, "R6 status bit", int'(rv[0]), int'(e_st));
         chk(rv[7] === e_en, "R6 enable readback", int'(rv[7]), int'(e_en));
      end
      reg_rd = 1'b0;
   endtask

   // R7: factor rewritten mid-period while running
   task automatic ratio_switch();
      int b, w;
      bit e;
      logic hi;
      wr(DIV_A, 8'd3);
      w = A + 5;
      b = A + 8;
      @(negedge clk);
      for (int j = -1; j <= b + 8; j++) begin
         @(posedge clk);
         #1 reg_wr = 1'b0;
         #0.5 hi = clk_out;
         #0.7;
         if (j == -1) begin
            reg_wr = 1'b1; reg_addr = EN_A; reg_wdata = 8'h80;
         end
         if (j == w - 1) begin
            reg_wr = 1'b1; reg_addr = DIV_A; reg_wdata = 8'd2;
         end
         if (j < A)      e = 1'b0;
         else if (j < b) e = ((j - A) % 4) < 2;
         else            e = ((j - b) % 2) == 0;
         chk(hi === e, "R7 ratio change at boundary", int'(hi), int'(e));
      end
      wr(EN_A, 8'h00);
      repeat (20) @(posedge clk);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R2: reset state
      rd(DIV_A, 1'b1, v); chk(v === 8'h00, "R2 reset factor", int'(v), 0);
      rd(EN_A, 1'b1, v);  chk(v === 8'h00, "R2 reset enable/status", int'(v), 0);
      chk(clk_out === 1'b0, "R2 reset output low", int'(clk_out), 0);
      // R2: unused bits
      wr(DIV_A, 8'hFD);
      rd(DIV_A, 1'b1, v); chk(v === 8'h05, "R2 factor keeps bits 2:0 only", int'(v), 5);
      wr(EN_A, 8'h7F);
      repeat (10) @(posedge clk);
      rd(EN_A, 1'b1, v);  chk(v === 8'h00, "R2 enable ignores low bits", int'(v), 0);
      chk(clk_out === 1'b0, "R2 output idle after low-bit write", int'(clk_out), 0);
      // R1: decode
      wr(OTHER_D, 8'h02);
      rd(DIV_A, 1'b1, v); chk(v === 8'h05, "R1 other channel write ignored", int'(v), 5);
      wr(OTHER_E, 8'h80);
      repeat (10) @(posedge clk);
      rd(EN_A, 1'b1, v);  chk(v === 8'h00, "R1 other channel enable ignored", int'(v), 0);
      chk(clk_out === 1'b0, "R1 output idle after foreign enable", int'(clk_out), 0);
      rd(16'h1144, 1'b1, v); chk(v === 8'h00, "R1 unmapped read zero", int'(v), 0);
      rd(DIV_A, 1'b0, v);    chk(v === 8'h00, "R1 no strobe reads zero", int'(v), 0);
      // factor sweep with three disable placements
      for (int f = 0; f < 8; f++) begin
         int r;
         r = ratio_of(f);
         run_case(f, 1);
         run_case(f, A + r + r / 2);
         run_case(f, A + 2 * r - 1);
      end
      ratio_switch();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule